// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block keeps the divider settings of a frequency synthesizer: a 9-bit feedback count, a 2-bit post-divide code and a 3-bit test-select field. Downstream divider and test-multiplexer logic reads these registers.

The settings can arrive in two ways. A parallel bus carries the feedback count and the post-divide code, and an active-low load strobe qualifies it. A three-wire serial port carries a data line, a shift clock and an active-high load strobe. The serial frame also carries the test-select field, which only the serial port can set.

All control pins are asynchronous to the system clock. The block passes them through flop synchronisers and detects their levels and edges inside one clock domain. It models both load strobes as level-sensitive latches. Downstream logic receives a one-cycle notice whenever the feedback count or the post-divide code changes.

Top module: `synth_div_cfg`

## Requirements
- R1: After synchronous reset, with the parallel strobe high and the serial strobe low, the feedback count, post-divide code and test field all read zero, and the update pulse stays low.
- R2: The shift register is 14 bits wide and moves by one bit on each rising edge of the serial clock, taking the data line as its new least significant bit. Falling edges do not move it. When a complete frame is loaded, the bits sent first-to-last are T2 T1 T0, then N1 N0, then M8 down to M0. Each field arrives most significant bit first.
- R3: While the serial strobe is high and the parallel strobe is high, all three registers follow the shift register contents. Once the serial strobe falls, further shifting leaves them unchanged.
- R4: While the parallel strobe is low, the feedback count and post-divide code follow the parallel bus. Once the strobe rises, they keep the last bus value, and later bus changes have no effect.
- R5: While the parallel strobe is low, the test field reads 000. A parallel load never sets it to anything else.
- R6: When the parallel strobe is low and the serial strobe is high at the same time, the parallel bus wins and the test field reads 000. A serial load takes effect only while the parallel strobe is high.
- R7: The update output pulses high for exactly the cycles in which the registered feedback count or post-divide code differs from its previous value. A change to the test field alone, or a reload of the same values, gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_load_i | input | 1 | Parallel load strobe, asynchronous, transparent while low |
| par_m_i | input | 9 | Parallel feedback count |
| par_n_i | input | 2 | Parallel post-divide code |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_data_i | input | 1 | Serial data line |
| ser_load_i | input | 1 | Serial load strobe, asynchronous, transparent while high |
| m_o | output | 9 | Latched feedback count |
| n_o | output | 2 | Latched post-divide code |
| t_o | output | 3 | Latched test-select field |
| config_updated_o | output | 1 | One-cycle pulse per change of feedback count or post-divide code |

## Verification
Both load strobes can be active in the same cycle: the parallel strobe is low while the serial strobe is high. The bench first loads a frame with a non-zero test field into the shift register. It then raises the serial strobe and lowers the parallel strobe together. The outputs must show the parallel bus with the test field at zero. The bench then raises the parallel strobe while the serial strobe is still high, and the outputs must switch to the shifted frame. That second step shows that the serial path was only held back and was not lost.

// File: rtl/synth_div_cfg_pkg.sv
// Shared sizing for the divider configuration port.
package synth_div_cfg_pkg;
    localparam int unsigned CFG_M_W    = 9;
    localparam int unsigned CFG_N_W    = 2;
    localparam int unsigned CFG_T_W    = 3;
    localparam int unsigned CFG_SYNC_N = 2;
endpackage

// File: rtl/cfg_sync.sv
// cfg_sync: multi-stage flop synchroniser for a vector of quasi-static or
// slow asynchronous signals. Assumes each bit is independent or held stable
// long enough that skew between bits does not matter to the consumer.
module cfg_sync #(
    parameter int unsigned     W       = 1,
    parameter int unsigned     STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe [STAGES];

    // Shift the asynchronous input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d_i;
            for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
// cfg_shifter: serial frame shift register. Advances once per detected
// rising edge of the synchronised serial clock. Assumes the serial clock is
// much slower than clk and data is synchronised with the same latency.
module cfg_shifter #(
    parameter int unsigned FRAME_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s_i,
    input  logic               sdat_s_i,
    output logic [FRAME_W-1:0] frame_o
);
    logic               sclk_prev;
    logic               sclk_rise;
    logic [FRAME_W-1:0] shreg;

    assign sclk_rise = sclk_s_i & ~sclk_prev;

    // Remember the last serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s_i;
    end

    // Shift in one data bit at each rising serial clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         shreg <= '0;
        else if (sclk_rise) shreg <= {shreg[FRAME_W-2:0], sdat_s_i};
    end

    assign frame_o = shreg;

    // R2: without a rising serial clock edge the register does not move.
    assert_shift_on_rise_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_s_i && !sclk_prev) |=> $stable(shreg));

    // R2: a rising edge moves the old low bits up by one place.
    assert_shift_moves_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_s_i && !sclk_prev) |=> (shreg[FRAME_W-1:1] == $past(shreg[FRAME_W-2:0])));
endmodule

// File: rtl/cfg_latch_bank.sv
// cfg_latch_bank: clocked model of the two transparent latch paths. The
// parallel path (strobe low) wins over the serial path (strobe high); the
// test field is cleared whenever the parallel path is open. Assumes all
// inputs are already synchronous to clk.
module cfg_latch_bank #(
    parameter int unsigned M_W = 9,
    parameter int unsigned N_W = 2,
    parameter int unsigned T_W = 3,
    localparam int unsigned FRAME_W = M_W + N_W + T_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               par_load_s_i,
    input  logic               ser_load_s_i,
    input  logic [M_W-1:0]     par_m_s_i,
    input  logic [N_W-1:0]     par_n_s_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic [M_W-1:0]     m_o,
    output logic [N_W-1:0]     n_o,
    output logic [T_W-1:0]     t_o,
    output logic               updated_o
);
    logic [M_W-1:0] m_q, m_d;
    logic [N_W-1:0] n_q, n_d;
    logic [T_W-1:0] t_q, t_d;
    logic           upd_q;

    logic [T_W-1:0] fr_t;
    logic [N_W-1:0] fr_n;
    logic [M_W-1:0] fr_m;

    // Split the frame: first-sent field sits at the top.
    assign fr_t = frame_i[FRAME_W-1 -: T_W];
    assign fr_n = frame_i[M_W +: N_W];
    assign fr_m = frame_i[M_W-1:0];

    // Pick the next latch contents by strobe priority.
    always_comb begin
        m_d = m_q;
        n_d = n_q;
        t_d = t_q;
        if (!par_load_s_i) begin
            m_d = par_m_s_i;
            n_d = par_n_s_i;
            t_d = '0;
        end else if (ser_load_s_i) begin
            m_d = fr_m;
            n_d = fr_n;
            t_d = fr_t;
        end
    end

    // Hold the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
            n_q <= '0;
            t_q <= '0;
        end else begin
            m_q <= m_d;
            n_q <= n_d;
            t_q <= t_d;
        end
    end

    // Flag a change of the divider values in the same cycle it shows.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= (m_d != m_q) || (n_d != n_q);
    end

    assign m_o       = m_q;
    assign n_o       = n_q;
    assign t_o       = t_q;
    assign updated_o = upd_q;

    // R5: an open parallel path leaves the test field at zero.
    assert_t_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !par_load_s_i |=> (t_q == '0));

    // R6: the parallel bus wins whatever the serial strobe does.
    assert_par_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !par_load_s_i |=> (m_q == $past(par_m_s_i)) && (n_q == $past(par_n_s_i)));

    // R3: with both paths closed, every register holds.
    assert_closed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (par_load_s_i && !ser_load_s_i) |=> $stable(m_q) && $stable(n_q) && $stable(t_q));

    // R7: the pulse marks exactly the cycles where a divider value moved.
    assert_pulse_tracks_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q == ((m_q != $past(m_q)) || (n_q != $past(n_q))));
endmodule

// File: rtl/synth_div_cfg.sv
// synth_div_cfg: divider configuration port with a parallel and a serial
// load path. Synchronises the asynchronous strobes, serial clock and data,
// and the parallel bus, then drives the shift register and latch bank.
// Assumes the serial clock and strobes are slow relative to clk.
module synth_div_cfg
    import synth_div_cfg_pkg::*;
#(
    parameter int unsigned M_W    = CFG_M_W,
    parameter int unsigned N_W    = CFG_N_W,
    parameter int unsigned T_W    = CFG_T_W,
    parameter int unsigned SYNC_N = CFG_SYNC_N
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_load_i,
    input  logic [M_W-1:0] par_m_i,
    input  logic [N_W-1:0] par_n_i,
    input  logic           ser_clk_i,
    input  logic           ser_data_i,
    input  logic           ser_load_i,
    output logic [M_W-1:0] m_o,
    output logic [N_W-1:0] n_o,
    output logic [T_W-1:0] t_o,
    output logic           config_updated_o
);
    localparam int unsigned FRAME_W = M_W + N_W + T_W;
    localparam int unsigned BUS_W   = M_W + N_W;

    logic [3:0]         ctl_raw, ctl_s;
    logic [BUS_W-1:0]   bus_s;
    logic [FRAME_W-1:0] frame;

    // Control order: parallel strobe, serial strobe, serial clock, data.
    assign ctl_raw = {par_load_i, ser_load_i, ser_clk_i, ser_data_i};

    cfg_sync #(.W(4), .STAGES(SYNC_N), .RST_VAL(4'b1000)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ctl_raw), .q_o(ctl_s)
    );

    cfg_sync #(.W(BUS_W), .STAGES(SYNC_N), .RST_VAL({BUS_W{1'b1}})) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d_i({par_m_i, par_n_i}), .q_o(bus_s)
    );

    cfg_shifter #(.FRAME_W(FRAME_W)) u_shifter (
        .clk(clk), .rst_n(rst_n),
        .sclk_s_i(ctl_s[1]), .sdat_s_i(ctl_s[0]),
        .frame_o(frame)
    );

    cfg_latch_bank #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_latches (
        .clk(clk), .rst_n(rst_n),
        .par_load_s_i(ctl_s[3]), .ser_load_s_i(ctl_s[2]),
        .par_m_s_i(bus_s[BUS_W-1:N_W]), .par_n_s_i(bus_s[N_W-1:0]),
        .frame_i(frame),
        .m_o(m_o), .n_o(n_o), .t_o(t_o), .updated_o(config_updated_o)
    );

    // R1: after reset nothing has been loaded yet.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (m_o == '0) && (n_o == '0) && (t_o == '0) && !config_updated_o);
endmodule

// File: tb/synth_div_cfg_test.sv
module synth_div_cfg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_load_i = 1'b1;
    logic [8:0] par_m_i = 9'h1FF;
    logic [1:0] par_n_i = 2'b11;
    logic       ser_clk_i = 1'b0;
    logic       ser_data_i = 1'b0;
    logic       ser_load_i = 1'b0;
    logic [8:0] m_o;
    logic [1:0] n_o;
    logic [2:0] t_o;
    logic       config_updated_o;

    int tests = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 1'b0;
    logic [13:0] mdl_sr = '0;

    always #2 clk = ~clk;

    synth_div_cfg uut (
        .clk(clk), .rst_n(rst_n),
        .par_load_i(par_load_i), .par_m_i(par_m_i), .par_n_i(par_n_i),
        .ser_clk_i(ser_clk_i), .ser_data_i(ser_data_i), .ser_load_i(ser_load_i),
        .m_o(m_o), .n_o(n_o), .t_o(t_o), .config_updated_o(config_updated_o)
    );

    always @(posedge clk) if (rst_n && config_updated_o) pulses++;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_data_i = b;
        wait_cyc(6);
        ser_clk_i = 1'b1;
        mdl_sr = {mdl_sr[12:0], b};
        wait_cyc(6);
        ser_clk_i = 1'b0;
        wait_cyc(6);
    endtask

    task automatic shift_frame(input logic [2:0] t, input logic [1:0] n, input logic [8:0] m);
        logic [13:0] f;
        f = {t, n, m};
        for (int i = 13; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic ser_strobe();
        ser_load_i = 1'b1;
        wait_cyc(8);
        ser_load_i = 1'b0;
        wait_cyc(8);
    endtask

    task automatic check_out(input string req, input logic [2:0] t, input logic [1:0] n, input logic [8:0] m);
        check(req, "m", int'(m_o), int'(m));
        check(req, "n", int'(n_o), int'(n));
        check(req, "t", int'(t_o), int'(t));
    endtask

    task automatic t_reset();
        check_out("R1", 3'd0, 2'd0, 9'd0);
        check("R1", "pulses", pulses, 0);
    endtask

    task automatic t_serial_frame();
        int p0;
        p0 = pulses;
        shift_frame(3'b101, 2'b10, 9'h1A5);
        check("R2", "frame before strobe m", int'(m_o), 0);
        ser_strobe();
        check_out("R2", 3'b101, 2'b10, 9'h1A5);
        check("R7", "one pulse for frame", pulses - p0, 1);
    endtask

    task automatic t_frozen_then_transparent();
        int p0;
        p0 = pulses;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        check_out("R3 frozen", 3'b101, 2'b10, 9'h1A5);
        check("R3", "no pulse frozen", pulses - p0, 0);
        ser_load_i = 1'b1;
        wait_cyc(8);
        check_out("R3 open", mdl_sr[13:11], mdl_sr[10:9], mdl_sr[8:0]);
        send_bit(1'b1);
        check_out("R3 follow", mdl_sr[13:11], mdl_sr[10:9], mdl_sr[8:0]);
        ser_load_i = 1'b0;
        wait_cyc(8);
    endtask

    task automatic t_test_field_only();
        int p0;
        shift_frame(3'b000, 2'b01, 9'h0C8);
        ser_strobe();
        p0 = pulses;
        shift_frame(3'b110, 2'b01, 9'h0C8);
        ser_strobe();
        check_out("R7", 3'b110, 2'b01, 9'h0C8);
        check("R7", "no pulse for t only", pulses - p0, 0);
    endtask

    task automatic t_parallel();
        par_m_i = 9'h0F3; par_n_i = 2'b01;
        par_load_i = 1'b0;
        wait_cyc(8);
        check_out("R4 R5 open", 3'b000, 2'b01, 9'h0F3);
        par_m_i = 9'h106; par_n_i = 2'b00;
        wait_cyc(8);
        check_out("R4 follow", 3'b000, 2'b00, 9'h106);
        par_load_i = 1'b1;
        wait_cyc(8);
        par_m_i = 9'h055; par_n_i = 2'b11;
        wait_cyc(8);
        check_out("R4 R5 held", 3'b000, 2'b00, 9'h106);
    endtask

    task automatic t_priority();
        shift_frame(3'b011, 2'b10, 9'h12C);
        par_m_i = 9'h0AA; par_n_i = 2'b01;
        @(negedge clk);
        par_load_i = 1'b0;
        ser_load_i = 1'b1;
        wait_cyc(8);
        check_out("R6 both open", 3'b000, 2'b01, 9'h0AA);
        par_load_i = 1'b1;
        wait_cyc(8);
        check_out("R6 serial after release", 3'b011, 2'b10, 9'h12C);
        ser_load_i = 1'b0;
        wait_cyc(8);
    endtask

    task automatic t_same_value();
        int p0;
        par_m_i = 9'h12C; par_n_i = 2'b10;
        p0 = pulses;
        par_load_i = 1'b0;
        wait_cyc(8);
        par_load_i = 1'b1;
        wait_cyc(8);
        check_out("R7 reload", 3'b000, 2'b10, 9'h12C);
        check("R7", "no pulse same value", pulses - p0, 0);
        p0 = pulses;
        par_m_i = 9'h12D;
        par_load_i = 1'b0;
        wait_cyc(8);
        par_load_i = 1'b1;
        wait_cyc(8);
        check("R7", "one pulse on change", pulses - p0, 1);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(8);
        t_reset();
        t_serial_frame();
        t_frozen_then_transparent();
        t_test_field_only();
        t_parallel();
        t_priority();
        t_same_value();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule